// File: doc/BRIEF.md
# Flash Command Sequencer with Failure Lockout

This block sits between a processor-style byte bus and the control side of an embedded flash array. Software drives operations with short command scripts made of bus writes: a two-write unlock preamble, a command code, and then either the bytes of one page (program) or a second unlock preamble and an erase selector (block erase or whole-array erase). The sequencer checks every write against the expected script. Any mismatch drops the script and leaves the array untouched.

Once a script completes, the sequencer compares the target against a per-block write-protect bitmap. A permitted request becomes one or more array operations, run through a start/done/fail handshake. A whole-array erase becomes a series of block erases over the unprotected blocks, in ascending order. While an operation runs, reads on the bus return a status byte instead of array data, and further writes are dropped. A failure report from the array freezes the sequencer in a busy, locked state. Only the synchronous hardware reset releases it.

Fixed command values: unlock writes are 0xAA to address 0x5554, then 0x55 to address 0xAAAA. The program code is 0xA0 and the erase code is 0x80, both written to 0x5554. The erase selectors are 0x10 to 0x5554 for the whole array, and 0x30 to any address inside the target block.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset, flash_ready is 1, arr_start is 0, and the command script starts from its first step.
- R2: While flash_ready is 1, bus_rdata equals arr_rd_data, and arr_rd_addr follows bus_addr.
- R3: A script must open with 0xAA at 0x5554 and then 0x55 at 0xAAAA. A wrong data value or a wrong address in any script step abandons the script without any array operation.
- R4: The program script is the unlock, then 0xA0 at 0x5554, then exactly PAGE_BYTES data writes. The final data write issues one operation with arr_op = 2'b01 and arr_addr = the page base (address bits [1:0] cleared). Byte lane i of arr_wdata (bits 8i+7:8i) holds the byte written to page offset i. Lanes never written hold 0xFF.
- R5: A data write whose page (address bits [15:2]) differs from the page of the first data write abandons the program script with no operation.
- R6: From the fourth write of a program script onward, a 0xF0 value is taken as page data and does not end the script. In steps 2 and 3, 0xF0 ends the script.
- R7: The block erase script is the unlock, 0x80 at 0x5554, 0xAA at 0x5554, 0x55 at 0xAAAA, then 0x30 at any address in the block. No operation starts before that sixth write. The operation has arr_op = 2'b10 and arr_addr = the block base (address bits [12:0] cleared; the block number is bits [15:13]).
- R8: Replacing the sixth write with 0x10 at 0x5554 erases the whole array as consecutive block erases of every unprotected block, in ascending block order.
- R9: A program or block erase aimed at a block whose blk_protect bit is 1 issues no operation, and flash_ready stays 1.
- R10: A whole-array erase with every blk_protect bit set issues no operation, and flash_ready is 1 right after the sixth write.
- R11: flash_ready is 0 from the cycle after an accepted final write until the array's done is sampled. While flash_ready is 0, bus_rdata is the status byte: bit 0 is ready, bit 1 is locked, bit 2 is erase in progress, and the other bits are 0.
- R12: Bus writes while flash_ready is 0 are ignored and start no new operation.
- R13: When arr_fail is sampled during an operation, flash_ready stays 0 and status bit 1 is set until rst. Writes are ignored in that state.
- R14: Each array operation raises arr_start for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| bus_we | input | 1 | Bus write strobe, one cycle per write |
| bus_addr | input | 16 | Bus byte address |
| bus_wdata | input | 8 | Bus write data |
| bus_rdata | output | 8 | Array data when ready, otherwise the status byte |
| flash_ready | output | 1 | Ready/busy flag, same value as status bit 0 |
| blk_protect | input | 8 | Write-protect bit per block |
| arr_start | output | 1 | One-cycle start of an array operation |
| arr_op | output | 2 | Operation code: 01 program, 10 block erase |
| arr_addr | output | 16 | Page base or block base of the operation |
| arr_wdata | output | 32 | Page data, lane i is offset i |
| arr_done | input | 1 | Array reports successful completion |
| arr_fail | input | 1 | Array reports failure |
| arr_rd_addr | output | 16 | Read address to the array |
| arr_rd_data | input | 8 | Read data from the array |

## Verification
The final write of an accepted script is taken at a clock edge. By the next falling-edge sample, arr_start is high and flash_ready is low. The bench samples both right when its write task returns, and a rejected script shows flash_ready still high at that same sample. The array model raises done a fixed latency after the start it saw. flash_ready rises at the edge that samples done, so the bench polls for ready at falling edges under a bound. Expected operations are queued before each script. A falling-edge monitor takes one entry per arr_start pulse, so a missing operation, an extra operation, or a wrong field is flagged at the cycle it occurs.

// File: rtl/fseq_pkg.sv
`timescale 1ns/1ps
package fseq_pkg;

    typedef enum logic [2:0] {
        D_IDLE, D_UNL2, D_CMD, D_PDATA, D_EUNL1, D_EUNL2, D_ESEL
    } dec_state_e;

    typedef enum logic [1:0] {
        REQ_PROG   = 2'd0,
        REQ_BERASE = 2'd1,
        REQ_CERASE = 2'd2
    } req_kind_e;

    typedef enum logic [1:0] {
        ARR_NOP    = 2'd0,
        ARR_PROG   = 2'd1,
        ARR_BERASE = 2'd2
    } arr_op_e;

    typedef enum logic [2:0] {
        E_IDLE, E_SCAN, E_ISSUE, E_WAIT, E_LOCK
    } eng_state_e;

    localparam logic [7:0] CODE_UNL1  = 8'hAA;
    localparam logic [7:0] CODE_UNL2  = 8'h55;
    localparam logic [7:0] CODE_PROG  = 8'hA0;
    localparam logic [7:0] CODE_ERASE = 8'h80;
    localparam logic [7:0] CODE_CHIP  = 8'h10;
    localparam logic [7:0] CODE_BLOCK = 8'h30;
    localparam logic [7:0] ERASED     = 8'hFF;

    typedef struct packed {
        logic erasing;
        logic locked;
        logic ready;
    } stat_t;

    function automatic logic [7:0] status_byte(stat_t s);
        return {5'b0, s.erasing, s.locked, s.ready};
    endfunction

endpackage

// File: rtl/fseq_page_buf.sv
`timescale 1ns/1ps
module fseq_page_buf
    import fseq_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int PAGE_BYTES = 4,
    localparam int OFF_W     = $clog2(PAGE_BYTES)
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         clear,
    input  logic                         load,
    input  logic [OFF_W-1:0]             off,
    input  logic [DATA_W-1:0]            din,
    output logic [PAGE_BYTES*DATA_W-1:0] page
);
    logic [PAGE_BYTES-1:0][DATA_W-1:0] lane_q;

    for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst || clear) begin
                lane_q[g] <= DATA_W'(ERASED);
            end else if (load && off == OFF_W'(g)) begin
                lane_q[g] <= din;
            end
        end
    end

    assign page = lane_q;

endmodule

// File: rtl/fseq_decoder.sv
`timescale 1ns/1ps
module fseq_decoder
    import fseq_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int DATA_W      = 8,
    parameter int PAGE_BYTES  = 4,
    parameter logic [ADDR_W-1:0] UNL_ADDR1 = 16'h5554,
    parameter logic [ADDR_W-1:0] UNL_ADDR2 = 16'hAAAA,
    localparam int OFF_W      = $clog2(PAGE_BYTES),
    localparam int PG_W       = ADDR_W - OFF_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              req_valid,
    output req_kind_e         req_kind,
    output logic [ADDR_W-1:0] req_addr,
    output logic              pg_clear,
    output logic              pg_load,
    output logic [OFF_W-1:0]  pg_off
);
    dec_state_e       st_q, st_d;
    logic [OFF_W-1:0] cnt_q, cnt_d;
    logic [PG_W-1:0]  page_q, page_d;
    logic [PG_W-1:0]  cur_page;

    assign cur_page = wr_addr[ADDR_W-1:OFF_W];
    assign pg_off   = wr_addr[OFF_W-1:0];

    function automatic logic hit(input logic [DATA_W-1:0] d, input logic [ADDR_W-1:0] a,
                                 input logic [7:0] code, input logic [ADDR_W-1:0] want);
        return (d == DATA_W'(code)) && (a == want);
    endfunction

    always_comb begin
        st_d      = st_q;
        cnt_d     = cnt_q;
        page_d    = page_q;
        req_valid = 1'b0;
        req_kind  = REQ_PROG;
        req_addr  = wr_addr;
        pg_clear  = 1'b0;
        pg_load   = 1'b0;
        if (wr_en) begin
            unique case (st_q)
                D_IDLE: begin
                    if (hit(wr_data, wr_addr, CODE_UNL1, UNL_ADDR1)) st_d = D_UNL2;
                end
                D_UNL2: begin
                    st_d = hit(wr_data, wr_addr, CODE_UNL2, UNL_ADDR2) ? D_CMD : D_IDLE;
                end
                D_CMD: begin
                    if (hit(wr_data, wr_addr, CODE_PROG, UNL_ADDR1)) begin
                        st_d     = D_PDATA;
                        cnt_d    = '0;
                        pg_clear = 1'b1;
                    end else if (hit(wr_data, wr_addr, CODE_ERASE, UNL_ADDR1)) begin
                        st_d = D_EUNL1;
                    end else begin
                        st_d = D_IDLE;
                    end
                end
                D_PDATA: begin
                    if (cnt_q != '0 && cur_page != page_q) begin
                        st_d = D_IDLE;
                    end else begin
                        pg_load = 1'b1;
                        if (cnt_q == '0) page_d = cur_page;
                        if (cnt_q == OFF_W'(PAGE_BYTES - 1)) begin
                            req_valid = 1'b1;
                            req_kind  = REQ_PROG;
                            req_addr  = {page_q, {OFF_W{1'b0}}};
                            st_d      = D_IDLE;
                        end else begin
                            cnt_d = cnt_q + 1'b1;
                        end
                    end
                end
                D_EUNL1: begin
                    st_d = hit(wr_data, wr_addr, CODE_UNL1, UNL_ADDR1) ? D_EUNL2 : D_IDLE;
                end
                D_EUNL2: begin
                    st_d = hit(wr_data, wr_addr, CODE_UNL2, UNL_ADDR2) ? D_ESEL : D_IDLE;
                end
                D_ESEL: begin
                    st_d = D_IDLE;
                    if (hit(wr_data, wr_addr, CODE_CHIP, UNL_ADDR1)) begin
                        req_valid = 1'b1;
                        req_kind  = REQ_CERASE;
                    end else if (wr_data == DATA_W'(CODE_BLOCK)) begin
                        req_valid = 1'b1;
                        req_kind  = REQ_BERASE;
                    end
                end
                default: st_d = D_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= D_IDLE;
            cnt_q  <= '0;
            page_q <= '0;
        end else begin
            st_q   <= st_d;
            cnt_q  <= cnt_d;
            page_q <= page_d;
        end
    end

    // R4
    prog_req_only_from_data_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_kind == REQ_PROG) |=> (st_q == D_IDLE));

endmodule

// File: rtl/fseq_engine.sv
`timescale 1ns/1ps
module fseq_engine
    import fseq_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int NUM_BLK = 8,
    localparam int BLK_W  = $clog2(NUM_BLK),
    localparam int LOW_W  = ADDR_W - BLK_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  req_kind_e          req_kind,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [NUM_BLK-1:0] blk_protect,
    input  logic               arr_done,
    input  logic               arr_fail,
    output logic               arr_start,
    output arr_op_e            arr_op,
    output logic [ADDR_W-1:0]  arr_addr,
    output logic               busy,
    output logic               locked,
    output logic               erasing
);
    eng_state_e        st_q, st_d;
    arr_op_e           op_q, op_d;
    logic [ADDR_W-1:0] addr_q, addr_d;
    logic              chip_q, chip_d;
    logic [BLK_W-1:0]  idx_q, idx_d;
    logic [BLK_W-1:0]  req_blk;

    localparam logic [BLK_W-1:0] LAST_BLK = BLK_W'(NUM_BLK - 1);

    assign req_blk = req_addr[ADDR_W-1 -: BLK_W];

    always_comb begin
        st_d   = st_q;
        op_d   = op_q;
        addr_d = addr_q;
        chip_d = chip_q;
        idx_d  = idx_q;
        unique case (st_q)
            E_IDLE: begin
                if (req_valid) begin
                    unique case (req_kind)
                        REQ_PROG: if (!blk_protect[req_blk]) begin
                            st_d   = E_ISSUE;
                            op_d   = ARR_PROG;
                            addr_d = req_addr;
                            chip_d = 1'b0;
                        end
                        REQ_BERASE: if (!blk_protect[req_blk]) begin
                            st_d   = E_ISSUE;
                            op_d   = ARR_BERASE;
                            addr_d = {req_blk, {LOW_W{1'b0}}};
                            chip_d = 1'b0;
                        end
                        REQ_CERASE: if (!(&blk_protect)) begin
                            st_d   = E_SCAN;
                            op_d   = ARR_BERASE;
                            chip_d = 1'b1;
                            idx_d  = '0;
                        end
                        default: ;
                    endcase
                end
            end
            E_SCAN: begin
                if (!blk_protect[idx_q]) begin
                    st_d   = E_ISSUE;
                    addr_d = {idx_q, {LOW_W{1'b0}}};
                end else if (idx_q == LAST_BLK) begin
                    st_d = E_IDLE;
                end else begin
                    idx_d = idx_q + 1'b1;
                end
            end
            E_ISSUE: st_d = E_WAIT;
            E_WAIT: begin
                if (arr_fail) begin
                    st_d = E_LOCK;
                end else if (arr_done) begin
                    if (chip_q && idx_q != LAST_BLK) begin
                        idx_d = idx_q + 1'b1;
                        st_d  = E_SCAN;
                    end else begin
                        st_d = E_IDLE;
                    end
                end
            end
            E_LOCK: st_d = E_LOCK;
            default: st_d = E_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= E_IDLE;
            op_q   <= ARR_NOP;
            addr_q <= '0;
            chip_q <= 1'b0;
            idx_q  <= '0;
        end else begin
            st_q   <= st_d;
            op_q   <= op_d;
            addr_q <= addr_d;
            chip_q <= chip_d;
            idx_q  <= idx_d;
        end
    end

    assign arr_start = (st_q == E_ISSUE);
    assign busy      = (st_q != E_IDLE);
    assign locked    = (st_q == E_LOCK);
    assign erasing   = busy && (op_q == ARR_BERASE);
    assign arr_op    = busy ? op_q : ARR_NOP;
    assign arr_addr  = addr_q;

    // R14
    start_single_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        arr_start |=> !arr_start);

    // R13
    lock_is_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        locked |=> locked);

    // R13
    fail_enters_lock_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == E_WAIT && arr_fail) |=> locked);

    // R9
    no_erase_protected_chk: assert property (@(posedge clk) disable iff (rst)
        (arr_start && $stable(blk_protect)) |-> !blk_protect[arr_addr[ADDR_W-1 -: BLK_W]]);

endmodule

// File: rtl/flash_cmd_seq.sv
`timescale 1ns/1ps
module flash_cmd_seq
    import fseq_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 8,
    parameter int NUM_BLK    = 8,
    parameter int PAGE_BYTES = 4,
    parameter logic [ADDR_W-1:0] UNL_ADDR1 = 16'h5554,
    parameter logic [ADDR_W-1:0] UNL_ADDR2 = 16'hAAAA,
    localparam int OFF_W     = $clog2(PAGE_BYTES),
    localparam int PAGE_W    = PAGE_BYTES * DATA_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_we,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic               flash_ready,
    input  logic [NUM_BLK-1:0] blk_protect,
    output logic               arr_start,
    output logic [1:0]         arr_op,
    output logic [ADDR_W-1:0]  arr_addr,
    output logic [PAGE_W-1:0]  arr_wdata,
    input  logic               arr_done,
    input  logic               arr_fail,
    output logic [ADDR_W-1:0]  arr_rd_addr,
    input  logic [DATA_W-1:0]  arr_rd_data
);
    logic              busy, locked, erasing;
    logic              wr_ok;
    logic              req_valid;
    req_kind_e         req_kind;
    logic [ADDR_W-1:0] req_addr;
    logic              pg_clear, pg_load;
    logic [OFF_W-1:0]  pg_off;
    arr_op_e           op_e;
    stat_t             stat;

    assign wr_ok = bus_we && !busy;

    fseq_decoder #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_BYTES(PAGE_BYTES),
        .UNL_ADDR1(UNL_ADDR1), .UNL_ADDR2(UNL_ADDR2)
    ) u_dec (
        .clk(clk), .rst(rst),
        .wr_en(wr_ok), .wr_addr(bus_addr), .wr_data(bus_wdata),
        .req_valid(req_valid), .req_kind(req_kind), .req_addr(req_addr),
        .pg_clear(pg_clear), .pg_load(pg_load), .pg_off(pg_off)
    );

    fseq_page_buf #(
        .DATA_W(DATA_W), .PAGE_BYTES(PAGE_BYTES)
    ) u_buf (
        .clk(clk), .rst(rst),
        .clear(pg_clear), .load(pg_load), .off(pg_off), .din(bus_wdata),
        .page(arr_wdata)
    );

    fseq_engine #(
        .ADDR_W(ADDR_W), .NUM_BLK(NUM_BLK)
    ) u_eng (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_kind(req_kind), .req_addr(req_addr),
        .blk_protect(blk_protect),
        .arr_done(arr_done), .arr_fail(arr_fail),
        .arr_start(arr_start), .arr_op(op_e), .arr_addr(arr_addr),
        .busy(busy), .locked(locked), .erasing(erasing)
    );

    assign arr_op        = op_e;
    assign stat.ready    = !busy;
    assign stat.locked   = locked;
    assign stat.erasing  = erasing;
    assign flash_ready   = stat.ready;
    assign arr_rd_addr   = bus_addr;
    assign bus_rdata     = busy ? DATA_W'(status_byte(stat)) : arr_rd_data;

    // R11
    start_means_busy_chk: assert property (@(posedge clk) disable iff (rst)
        arr_start |-> !flash_ready);

    // R12
    no_request_while_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !flash_ready) |-> !req_valid);

endmodule

// File: tb/tb_flash_cmd_seq.sv
`timescale 1ns/1ps
module tb_flash_cmd_seq;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_we = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        flash_ready;
    logic [7:0]  blk_protect = '0;
    logic        arr_start;
    logic [1:0]  arr_op;
    logic [15:0] arr_addr;
    logic [31:0] arr_wdata;
    logic        arr_done = 1'b0;
    logic        arr_fail = 1'b0;
    logic [15:0] arr_rd_addr;
    logic [7:0]  arr_rd_data;

    int checks = 0;
    int errors = 0;
    int lat_cfg = 4;
    bit fail_mode = 1'b0;
    int busy_cnt = 0;

    typedef struct {
        logic [1:0]  op;
        logic [15:0] addr;
        logic [31:0] data;
        string       tag;
    } exp_t;
    exp_t exp_q[$];
    exp_t mon_e;

    always #2.5 clk = ~clk;

    flash_cmd_seq dut (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .flash_ready(flash_ready),
        .blk_protect(blk_protect), .arr_start(arr_start), .arr_op(arr_op),
        .arr_addr(arr_addr), .arr_wdata(arr_wdata), .arr_done(arr_done),
        .arr_fail(arr_fail), .arr_rd_addr(arr_rd_addr), .arr_rd_data(arr_rd_data)
    );

    function automatic logic [7:0] rd_model(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h3C;
    endfunction
    assign arr_rd_data = rd_model(arr_rd_addr);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // array model: done or fail after lat_cfg cycles
    always @(negedge clk) begin
        arr_done <= 1'b0;
        arr_fail <= 1'b0;
        if (arr_start) begin
            busy_cnt <= lat_cfg;
        end else if (busy_cnt != 0) begin
            busy_cnt <= busy_cnt - 1;
            if (busy_cnt == 1) begin
                if (fail_mode) arr_fail <= 1'b1;
                else           arr_done <= 1'b1;
            end
        end
    end

    // monitor: one expected item per start pulse
    always @(negedge clk) begin
        if (!rst && arr_start) begin
            if (exp_q.size() == 0) begin
                chk("R9/R12 unexpected start", 32'(arr_addr), 32'hFFFF_FFFF);
            end else begin
                mon_e = exp_q.pop_front();
                chk(mon_e.tag, 32'(arr_op), 32'(mon_e.op));
                chk(mon_e.tag, 32'(arr_addr), 32'(mon_e.addr));
                if (mon_e.op == 2'b01) chk(mon_e.tag, arr_wdata, mon_e.data);
            end
        end
    end

    task automatic push(input logic [1:0] op, input logic [15:0] a, input logic [31:0] d, input string tag);
        exp_t e;
        e.op = op; e.addr = a; e.data = d; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic unlock();
        wr(16'h5554, 8'hAA);
        wr(16'hAAAA, 8'h55);
    endtask

    task automatic erase_pre();
        unlock();
        wr(16'h5554, 8'h80);
        wr(16'h5554, 8'hAA);
        wr(16'hAAAA, 8'h55);
    endtask

    task automatic wait_ready();
        for (int i = 0; i < 500; i++) begin
            @(negedge clk);
            if (flash_ready) break;
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL R1 watchdog act=hung exp=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        do_reset();
        // R1 reset state
        chk("R1 ready", 32'(flash_ready), 32'd1);
        chk("R1 start", 32'(arr_start), 32'd0);
        // R2 passthrough
        bus_addr = 16'h1234;
        #1;
        chk("R2 read", 32'(bus_rdata), 32'(rd_model(16'h1234)));

        // R4 program, sequential page
        push(2'b01, 16'h2040, 32'h44332211, "R4");
        unlock(); wr(16'h5554, 8'hA0);
        wr(16'h2040, 8'h11); wr(16'h2041, 8'h22); wr(16'h2042, 8'h33);
        chk("R4 before last", 32'(flash_ready), 32'd1);
        wr(16'h2043, 8'h44);
        chk("R11 busy after last", 32'(flash_ready), 32'd0);
        chk("R11 status prog", 32'(bus_rdata), 32'h00);
        wait_ready();
        chk("R11 ready again", 32'(flash_ready), 32'd1);

        // R4 unwritten lanes stay erased (repeat offset 1)
        push(2'b01, 16'h0100, 32'hFFFF_BB0A, "R4 partial");
        unlock(); wr(16'h5554, 8'hA0);
        wr(16'h0100, 8'h0A); wr(16'h0101, 8'h99); wr(16'h0101, 8'hBB);
        wr(16'h0101, 8'hBB);
        wait_ready();

        // R6 0xF0 as page data in fourth write
        push(2'b01, 16'h3000, 32'h030201F0, "R6");
        unlock(); wr(16'h5554, 8'hA0);
        wr(16'h3000, 8'hF0);
        chk("R6 not reset", 32'(flash_ready), 32'd1);
        wr(16'h3001, 8'h01); wr(16'h3002, 8'h02); wr(16'h3003, 8'h03);
        chk("R6 started", 32'(flash_ready), 32'd0);
        wait_ready();

        // R6 0xF0 in step 2 aborts; following writes do nothing
        wr(16'h5554, 8'hAA); wr(16'hAAAA, 8'hF0);
        wr(16'h5554, 8'hA0);
        wr(16'h4000, 8'h01); wr(16'h4001, 8'h02); wr(16'h4002, 8'h03); wr(16'h4003, 8'h04);
        chk("R6 abort", 32'(flash_ready), 32'd1);

        // R3 wrong unlock address
        wr(16'h5555, 8'hAA); wr(16'hAAAA, 8'h55); wr(16'h5554, 8'hA0);
        wr(16'h4000, 8'h01); wr(16'h4001, 8'h02); wr(16'h4002, 8'h03); wr(16'h4003, 8'h04);
        chk("R3 bad addr", 32'(flash_ready), 32'd1);
        // R3 wrong command data
        unlock(); wr(16'h5554, 8'hA1);
        wr(16'h4000, 8'h01); wr(16'h4001, 8'h02); wr(16'h4002, 8'h03); wr(16'h4003, 8'h04);
        chk("R3 bad code", 32'(flash_ready), 32'd1);

        // R5 cross-page data
        unlock(); wr(16'h5554, 8'hA0);
        wr(16'h5000, 8'h01); wr(16'h5001, 8'h02); wr(16'h5004, 8'h03); wr(16'h5005, 8'h04);
        chk("R5 cross page", 32'(flash_ready), 32'd1);
        push(2'b01, 16'h5000, 32'hDDCCBBAA, "R5 fresh");
        unlock(); wr(16'h5554, 8'hA0);
        wr(16'h5000, 8'hAA); wr(16'h5001, 8'hBB); wr(16'h5002, 8'hCC); wr(16'h5003, 8'hDD);
        wait_ready();

        // R7 block erase, sixth write only
        push(2'b10, 16'h4000, 32'h0, "R7");
        erase_pre();
        chk("R7 five writes", 32'(flash_ready), 32'd1);
        wr(16'h4123, 8'h30);
        chk("R7 busy", 32'(flash_ready), 32'd0);
        chk("R11 status erase", 32'(bus_rdata), 32'h04);
        wait_ready();

        // R9 protected block erase and program
        blk_protect = 8'h01;
        erase_pre(); wr(16'h0010, 8'h30);
        chk("R9 erase", 32'(flash_ready), 32'd1);
        unlock(); wr(16'h5554, 8'hA0);
        wr(16'h0040, 8'h01); wr(16'h0041, 8'h02); wr(16'h0042, 8'h03); wr(16'h0043, 8'h04);
        chk("R9 prog", 32'(flash_ready), 32'd1);

        // R8 chip erase skipping protected blocks
        blk_protect = 8'hA5;
        push(2'b10, 16'h2000, 32'h0, "R8 b1");
        push(2'b10, 16'h6000, 32'h0, "R8 b3");
        push(2'b10, 16'h8000, 32'h0, "R8 b4");
        push(2'b10, 16'hC000, 32'h0, "R8 b6");
        erase_pre(); wr(16'h5554, 8'h10);
        chk("R8 busy", 32'(flash_ready), 32'd0);
        wait_ready();
        chk("R8 all issued", 32'(exp_q.size()), 32'd0);

        // R10 all protected
        blk_protect = 8'hFF;
        erase_pre(); wr(16'h5554, 8'h10);
        chk("R10 ready", 32'(flash_ready), 32'd1);
        repeat (10) @(negedge clk);
        blk_protect = 8'h00;

        // R12 writes ignored during long erase
        lat_cfg = 60;
        push(2'b10, 16'hE000, 32'h0, "R12");
        erase_pre(); wr(16'hE000, 8'h30);
        erase_pre(); wr(16'h2000, 8'h30);
        chk("R12 still busy", 32'(flash_ready), 32'd0);
        wait_ready();
        repeat (10) @(negedge clk);
        chk("R12 one op", 32'(exp_q.size()), 32'd0);
        lat_cfg = 4;

        // R13 failure lock
        fail_mode = 1'b1;
        push(2'b01, 16'h6000, 32'h04030201, "R13");
        unlock(); wr(16'h5554, 8'hA0);
        wr(16'h6000, 8'h01); wr(16'h6001, 8'h02); wr(16'h6002, 8'h03); wr(16'h6003, 8'h04);
        repeat (20) @(negedge clk);
        chk("R13 ready held", 32'(flash_ready), 32'd0);
        chk("R13 status", 32'(bus_rdata), 32'h02);
        fail_mode = 1'b0;
        erase_pre(); wr(16'h2000, 8'h30);
        repeat (10) @(negedge clk);
        chk("R13 still locked", 32'(flash_ready), 32'd0);
        do_reset();
        chk("R13 released", 32'(flash_ready), 32'd1);
        chk("R14 queue empty", 32'(exp_q.size()), 32'd0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule